// File: doc/BRIEF.md
# Static Memory Write Strobe Timer

This block turns write requests into the control waveform of an asynchronous static memory. It drives a shared active-low write enable, one active-low select line per memory bank, and the address, data and active-low byte-enable buses. Each bank has its own timing set, counted in clock cycles: write-enable setup and pulse width, select setup and pulse width, and a total cycle length. Hold times are never programmed. Each strobe's hold is whatever remains of the cycle after its setup and pulse, so both strobes end on the same cycle boundary.

The requester presents a request with `req_valid` and the payload, and the request is taken at a clock edge where `req_ready` is high. The write runs on the bus from the next cycle. `wr_ack` marks the last cycle of each write. `req_ready` is also high in that cycle, so a request that is waiting starts its write with no idle cycle between. If the next write goes to the same bank, a strobe with zero setup and zero hold stays asserted across the boundary. If it goes to a different bank, one turnaround cycle with every strobe released comes first. A request whose bank timing is illegal is taken and dropped, and `cfg_err` pulses.

Top module: `smc_write_timer`

## Requirements
- R1: While reset is asserted and after it is released, `mem_we_n` and every bit of `mem_cs_n` are 1, `wr_ack` and `cfg_err` are 0, and `req_ready` is 1.
- R2: A legal write taken at clock edge E occupies exactly `cycle` consecutive bus cycles, numbered 0 to `cycle`-1, starting right after E. `wr_ack` is 1 in cycle `cycle`-1 only.
- R3: `mem_we_n` is 0 exactly in bus cycles n with `we_setup` <= n < `we_setup`+`we_pulse`. It is 1 in the remaining `cycle`-`we_setup`-`we_pulse` hold cycles.
- R4: Bit k of `mem_cs_n`, where k is the bank index, is 0 exactly in bus cycles n with `cs_setup` <= n < `cs_setup`+`cs_pulse`. All other bits stay 1, and at most one bit is ever 0.
- R5: The timing used for a write is the set of the bank named by `req_cs` at acceptance. Bank k's fields occupy bits [k*TW +: TW] of each configuration input.
- R6: `mem_addr`, `mem_data` and `mem_be_n` (the bitwise inverse of `req_be`) take the accepted request's values at the start of bus cycle 0. They do not change until the next accepted request.
- R7: A request to the same bank that is waiting during the last cycle is taken at that edge and its cycle 0 follows at once. With zero setup and zero hold, the strobes stay low across the boundary without a single high cycle.
- R8: A request to a different bank taken in the last cycle of a write is followed by one turnaround cycle. In that cycle every strobe is 1 and `req_ready` is 0, and cycle 0 of the new write comes after it.
- R9: A request whose bank has `we_pulse` = 0 or `cs_pulse` = 0 is taken and dropped. No strobe asserts, no `wr_ack` follows, and `cfg_err` is 1 for the one cycle after the acceptance edge.
- R10: A request whose bank has `cycle` < `we_setup`+`we_pulse` or `cycle` < `cs_setup`+`cs_pulse` is rejected in the same way as in R9.
- R11: `req_ready` is 1 only when no write is in progress or in the last cycle of a write. In a cycle where `req_ready` is 1 and `wr_ack` is 0, every strobe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counts are in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_setup | input | NCS*TW | Write-enable setup per bank |
| cfg_we_pulse | input | NCS*TW | Write-enable pulse width per bank |
| cfg_cs_setup | input | NCS*TW | Select setup per bank |
| cfg_cs_pulse | input | NCS*TW | Select pulse width per bank |
| cfg_cycle | input | NCS*TW | Total write cycle length per bank |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | A presented request is taken at this edge |
| req_cs | input | CSW | Target bank index |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_be | input | DW/8 | Byte enables, active high |
| wr_ack | output | 1 | Last cycle of the current write |
| cfg_err | output | 1 | A request was dropped for illegal timing |
| mem_addr | output | AW | Memory address bus |
| mem_data | output | DW | Memory write data bus |
| mem_be_n | output | DW/8 | Memory byte enables, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cs_n | output | NCS | Bank selects, active low |

## Verification
The hardest situation to reach is the boundary between two writes. A request has to be waiting in exactly the last cycle of the previous write, so that the zero-setup, zero-hold case and the bank-change turnaround both happen. The bench keeps a queue of requests and holds `req_valid` high while the queue is not empty, so every request is presented during the preceding write's last cycle. Directed runs use a zero-setup, zero-hold bank, alternate between banks, and place illegal banks between legal writes. Random batches with occasional idle cycles then mix these boundaries under random legal timing.

// File: rtl/smc_write_timer.sv
module smc_write_timer #(
  parameter int NCS = 4,
  parameter int AW  = 24,
  parameter int DW  = 32,
  parameter int TW  = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCS*TW-1:0]     cfg_we_setup,
  input  logic [NCS*TW-1:0]     cfg_we_pulse,
  input  logic [NCS*TW-1:0]     cfg_cs_setup,
  input  logic [NCS*TW-1:0]     cfg_cs_pulse,
  input  logic [NCS*TW-1:0]     cfg_cycle,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [((NCS>1)?$clog2(NCS):1)-1:0] req_cs,
  input  logic [AW-1:0]         req_addr,
  input  logic [DW-1:0]         req_data,
  input  logic [DW/8-1:0]       req_be,
  output logic                  wr_ack,
  output logic                  cfg_err,
  output logic [AW-1:0]         mem_addr,
  output logic [DW-1:0]         mem_data,
  output logic [DW/8-1:0]       mem_be_n,
  output logic                  mem_we_n,
  output logic [NCS-1:0]        mem_cs_n
);
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int BEW = DW / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_RUN} st_t;

  function automatic logic fits(input logic [TW-1:0] cyc, input logic [TW-1:0] s, input logic [TW-1:0] p);
    return {1'b0, cyc} >= ({1'b0, s} + {1'b0, p});
  endfunction

  function automatic logic in_win(input logic [TW-1:0] c, input logic [TW-1:0] s, input logic [TW-1:0] p);
    return (c >= s) && ({1'b0, c} < ({1'b0, s} + {1'b0, p}));
  endfunction

  st_t            st, n_st;
  logic [TW-1:0]  cnt, n_cnt;
  logic [CSW-1:0] cur_cs, n_cs;
  logic [TW-1:0]  t_ws, t_wp, t_css, t_cp, t_cyc;
  logic [TW-1:0]  n_ws, n_wp, n_css, n_cp, n_cyc;
  logic [TW-1:0]  s_ws, s_wp, s_css, s_cp, s_cyc;
  logic           last, take, legal, good, we_on, cs_on;

  assign s_ws  = cfg_we_setup[req_cs*TW +: TW];
  assign s_wp  = cfg_we_pulse[req_cs*TW +: TW];
  assign s_css = cfg_cs_setup[req_cs*TW +: TW];
  assign s_cp  = cfg_cs_pulse[req_cs*TW +: TW];
  assign s_cyc = cfg_cycle[req_cs*TW +: TW];

  assign last      = (st == ST_RUN) && (cnt == t_cyc - TW'(1));
  assign req_ready = (st == ST_IDLE) || last;
  assign wr_ack    = last;
  assign take      = req_valid && req_ready;
  assign legal     = (s_wp != '0) && (s_cp != '0) && fits(s_cyc, s_ws, s_wp) && fits(s_cyc, s_css, s_cp);
  assign good      = take && legal;

  always_comb begin
    n_st  = st;
    n_cnt = cnt;
    n_cs  = cur_cs;
    n_ws  = t_ws;
    n_wp  = t_wp;
    n_css = t_css;
    n_cp  = t_cp;
    n_cyc = t_cyc;
    if (good) begin
      n_ws  = s_ws;
      n_wp  = s_wp;
      n_css = s_css;
      n_cp  = s_cp;
      n_cyc = s_cyc;
      n_cs  = req_cs;
      n_cnt = '0;
      n_st  = (last && (req_cs != cur_cs)) ? ST_GAP : ST_RUN;
    end else if (st == ST_GAP) begin
      n_st  = ST_RUN;
      n_cnt = '0;
    end else if (last) begin
      n_st  = ST_IDLE;
    end else if (st == ST_RUN) begin
      n_cnt = cnt + TW'(1);
    end
  end

  assign we_on = (n_st == ST_RUN) && in_win(n_cnt, n_ws, n_wp);
  assign cs_on = (n_st == ST_RUN) && in_win(n_cnt, n_css, n_cp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      cur_cs   <= '0;
      t_ws     <= '0;
      t_wp     <= '0;
      t_css    <= '0;
      t_cp     <= '0;
      t_cyc    <= '0;
      mem_addr <= '0;
      mem_data <= '0;
      mem_be_n <= '1;
      mem_we_n <= 1'b1;
      mem_cs_n <= '1;
      cfg_err  <= 1'b0;
    end else begin
      st       <= n_st;
      cnt      <= n_cnt;
      cur_cs   <= n_cs;
      t_ws     <= n_ws;
      t_wp     <= n_wp;
      t_css    <= n_css;
      t_cp     <= n_cp;
      t_cyc    <= n_cyc;
      mem_we_n <= ~we_on;
      mem_cs_n <= ~(NCS'(cs_on) << n_cs);
      cfg_err  <= take && !legal;
      if (good) begin
        mem_addr <= req_addr;
        mem_data <= req_data;
        mem_be_n <= ~req_be;
      end
    end
  end

  logic [BEW-1:0] unused_be_width;
  assign unused_be_width = req_be;
endmodule

// File: rtl/smc_write_timer_chk.sv
module smc_write_timer_chk #(
  parameter int NCS = 4,
  parameter int AW  = 24,
  parameter int DW  = 32,
  parameter int TW  = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  wr_ack,
  input logic                  cfg_err,
  input logic [AW-1:0]         mem_addr,
  input logic [DW-1:0]         mem_data,
  input logic [DW/8-1:0]       mem_be_n,
  input logic                  mem_we_n,
  input logic [NCS-1:0]        mem_cs_n
);
  logic live, took_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live   <= 1'b0;
      took_q <= 1'b0;
    end else begin
      live   <= 1'b1;
      took_q <= req_valid && req_ready;
    end
  end

  assert_single_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_cs_n) <= 1);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !wr_ack) |-> (mem_we_n && (&mem_cs_n)));

  assert_err_follows_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (live && cfg_err) |-> took_q);

  assert_reject_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (mem_we_n && (&mem_cs_n) && !wr_ack));

  assert_bus_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !took_q) |-> ($stable(mem_addr) && $stable(mem_data) && $stable(mem_be_n)));
endmodule

bind smc_write_timer smc_write_timer_chk #(.NCS(NCS), .AW(AW), .DW(DW), .TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .wr_ack    (wr_ack),
  .cfg_err   (cfg_err),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .mem_be_n  (mem_be_n),
  .mem_we_n  (mem_we_n),
  .mem_cs_n  (mem_cs_n)
);

// File: tb/smc_write_timer_tb.sv
module smc_write_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 4;
  localparam int AW  = 24;
  localparam int DW  = 32;
  localparam int TW  = 6;
  localparam int CSW = 2;
  localparam int BEW = DW / 8;
  localparam int QMAX = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCS*TW-1:0] cfg_we_setup = '0, cfg_we_pulse = '0, cfg_cs_setup = '0, cfg_cs_pulse = '0, cfg_cycle = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [CSW-1:0] req_cs = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [BEW-1:0] req_be = '0;
  logic wr_ack, cfg_err, mem_we_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic [BEW-1:0] mem_be_n;
  logic [NCS-1:0] mem_cs_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  smc_write_timer #(.NCS(NCS), .AW(AW), .DW(DW), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we_setup(cfg_we_setup), .cfg_we_pulse(cfg_we_pulse),
    .cfg_cs_setup(cfg_cs_setup), .cfg_cs_pulse(cfg_cs_pulse), .cfg_cycle(cfg_cycle),
    .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs),
    .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
    .wr_ack(wr_ack), .cfg_err(cfg_err),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_be_n(mem_be_n),
    .mem_we_n(mem_we_n), .mem_cs_n(mem_cs_n)
  );

  int n_chk = 0, n_fail = 0;
  int c_ws[NCS], c_wp[NCS], c_css[NCS], c_cp[NCS], c_cyc[NCS];
  int q_cs[QMAX];
  logic [AW-1:0] q_addr[QMAX];
  logic [DW-1:0] q_data[QMAX];
  logic [BEW-1:0] q_be[QMAX];
  int qh = 0, ql = 0;
  bit idle_mix = 0;

  int mst = 0, mcnt = 0, mcs = 0, mws = 0, mwp = 0, mcss = 0, mcp = 0, mcyc = 1;
  logic [AW-1:0] maddr = '0;
  logic [DW-1:0] mdata = '0;
  logic [BEW-1:0] mbe_n = '1;
  bit merr = 0, mb2b = 0;
  string merr_tag = "R9";
  bit track_r7 = 0;
  int r7_we_high = 0, r7_cs_high = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit legal_cfg(input int k);
    return c_wp[k] != 0 && c_cp[k] != 0 && c_cyc[k] >= c_ws[k] + c_wp[k] && c_cyc[k] >= c_css[k] + c_cp[k];
  endfunction

  function automatic bit pulse_bad(input int k);
    return c_wp[k] == 0 || c_cp[k] == 0;
  endfunction

  task automatic apply_cfg();
    for (int k = 0; k < NCS; k++) begin
      cfg_we_setup[k*TW +: TW] = TW'(c_ws[k]);
      cfg_we_pulse[k*TW +: TW] = TW'(c_wp[k]);
      cfg_cs_setup[k*TW +: TW] = TW'(c_css[k]);
      cfg_cs_pulse[k*TW +: TW] = TW'(c_cp[k]);
      cfg_cycle[k*TW +: TW]    = TW'(c_cyc[k]);
    end
  endtask

  task automatic set_bank(input int k, input int ws, input int wp, input int css, input int cp, input int cyc);
    c_ws[k] = ws; c_wp[k] = wp; c_css[k] = css; c_cp[k] = cp; c_cyc[k] = cyc;
  endtask

  task automatic push(input int cs);
    q_cs[ql]   = cs;
    q_addr[ql] = AW'($urandom);
    q_data[ql] = $urandom;
    q_be[ql]   = BEW'($urandom);
    ql++;
  endtask

  task automatic step();
    bit run, last, e_ready, e_we, have, acc, lg;
    logic [NCS-1:0] e_cs;
    string tw, tc;
    int k;
    run  = (mst == 2);
    last = run && (mcnt == mcyc - 1);
    e_ready = (mst == 0) || last;
    e_we = !(run && mcnt >= mws && mcnt < mws + mwp);
    e_cs = '1;
    if (run && mcnt >= mcss && mcnt < mcss + mcp) e_cs[mcs] = 1'b0;
    tw = (mst == 1) ? "R8" : (mb2b ? "R7" : "R3");
    tc = (mst == 1) ? "R8" : "R4 R5";
    chk("R11 ready", req_ready, e_ready);
    chk("R2 ack", wr_ack, last);
    chk({tw, " we_n"}, mem_we_n, e_we);
    chk({tc, " cs_n"}, mem_cs_n, e_cs);
    chk(merr ? merr_tag : "R9", cfg_err, merr);
    if (run) begin
      chk("R6 addr", mem_addr, maddr);
      chk("R6 data", mem_data, mdata);
      chk("R6 be_n", mem_be_n, mbe_n);
    end
    if (track_r7 && mst != 0) begin
      if (mem_we_n) r7_we_high++;
      if (mem_cs_n[0]) r7_cs_high++;
    end
    have = (qh < ql) && !(idle_mix && ($urandom % 4 == 0));
    req_valid = have;
    if (have) begin
      req_cs = CSW'(q_cs[qh]); req_addr = q_addr[qh]; req_data = q_data[qh]; req_be = q_be[qh];
    end
    acc = have && e_ready;
    merr = 0;
    if (acc) begin
      k = q_cs[qh];
      lg = legal_cfg(k);
      qh++;
      if (lg) begin
        mws = c_ws[k]; mwp = c_wp[k]; mcss = c_css[k]; mcp = c_cp[k]; mcyc = c_cyc[k];
        maddr = req_addr; mdata = req_data; mbe_n = ~req_be;
        mb2b = last && (k == mcs);
        mst  = (last && k != mcs) ? 1 : 2;
        mcs  = k;
        mcnt = 0;
      end else begin
        merr = 1;
        merr_tag = pulse_bad(k) ? "R9" : "R10";
        mst = 0;
        mb2b = 0;
      end
    end else if (mst == 1) begin
      mst = 2; mcnt = 0; mb2b = 0;
    end else if (last) begin
      mst = 0; mb2b = 0;
    end else if (run) begin
      mcnt++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    while (qh < ql || mst != 0 || merr) step();
    step();
    step();
    qh = 0; ql = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int k = 0; k < NCS; k++) set_bank(k, 1, 2, 0, 4, 4);
    apply_cfg();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 we_n in reset", mem_we_n, 1'b1);
    chk("R1 cs_n in reset", mem_cs_n, {NCS{1'b1}});
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 ready after reset", req_ready, 1'b1);
    chk("R1 ack after reset", wr_ack, 1'b0);
    chk("R1 err after reset", cfg_err, 1'b0);
    chk("R1 we_n after reset", mem_we_n, 1'b1);
    chk("R1 cs_n after reset", mem_cs_n, {NCS{1'b1}});

    set_bank(0, 0, 3, 0, 3, 3);
    apply_cfg();
    for (int i = 0; i < 4; i++) push(0);
    track_r7 = 1;
    drain();
    track_r7 = 0;
    chk("R7 we_n high cycles across same-bank boundaries", r7_we_high, 0);
    chk("R7 cs_n high cycles across same-bank boundaries", r7_cs_high, 0);

    set_bank(1, 1, 2, 0, 3, 3);
    set_bank(2, 0, 1, 1, 2, 4);
    apply_cfg();
    push(1); push(2); push(1); push(1); push(0); push(2);
    drain();

    set_bank(2, 0, 0, 0, 2, 3);
    set_bank(3, 2, 3, 0, 2, 4);
    apply_cfg();
    push(2); push(1); push(3); push(1); push(2); push(2); push(0);
    drain();

    idle_mix = 1;
    for (int b = 0; b < 25; b++) begin
      for (int k = 0; k < NCS; k++) begin
        int ws, wp, css, cp, mx;
        ws = $urandom % 4; wp = 1 + $urandom % 4; css = $urandom % 4; cp = 1 + $urandom % 4;
        mx = (ws + wp > css + cp) ? ws + wp : css + cp;
        set_bank(k, ws, wp, css, cp, mx + $urandom % 3);
        if ($urandom % 10 == 0) c_wp[k] = 0;
        if ($urandom % 10 == 0) c_cyc[k] = mx - 1;
      end
      apply_cfg();
      for (int i = 0; i < 20; i++) push($urandom % NCS);
      drain();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule